// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip requester and an external 32K x 8 asynchronous static RAM. The requester presents one request at a time: a 15-bit byte address, a read/write flag and, for writes, a data byte. The block turns each request into a sequence on the memory pins that meets the memory's minimum timing. The pins are an address bus, active-low select, output-enable and write-strobe lines, and a data bus split into an outgoing byte, an incoming byte and a drive-enable that controls the pad's three-state buffer.

Every timing minimum is given in nanoseconds as a parameter and turned into whole clock cycles by ceiling division against the clock-period parameter. A nonzero minimum always takes at least one cycle. A write is the window in which select and write strobe are both low. Address and data are set up one cycle before that window opens. The window lasts long enough to cover the strobe width, the address setup and the data setup. The bus stays driven for at least one cycle after the strobe rises.

A read holds select and output enable low for the longest of the access times. The returned byte is captured at the clock edge that ends that window. It is then reported with a single-cycle done pulse. A write that follows a read first spends a turnaround period with the bus undriven.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the first idle cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rsp_done is 0 and req_ready is 1.
- R2: A read holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for RD cycles, the ceiling of the largest of read cycle (55 ns), address access (55 ns) and output-enable access (25 ns) over the clock period (3 cycles at 20 ns). The address stays stable throughout.
- R3: rsp_done is high for exactly one cycle, in the cycle after an operation's last memory-pin cycle. After a read, rsp_rdata in that cycle equals the byte last written to that address.
- R4: For a write, mem_oe_n stays 1. Address and data are driven with mem_dq_oe=1 for one cycle with all enables high. Then mem_ce_n and mem_we_n fall together in the same cycle.
- R5: Select and write strobe stay low together for WR cycles. WR is the largest of: the strobe width ceiling (40 ns), the address-setup ceiling (45 ns) minus one, and the data-setup ceiling (25 ns) minus one, with a minimum of one. This gives 2 cycles at 20 ns.
- R6: After mem_ce_n and mem_we_n rise together, address and data stay driven with mem_dq_oe=1 for HOLD cycles. HOLD is the write-cycle ceiling (55 ns) minus WR minus one, with a minimum of one (1 at 20 ns). The bus is then released.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: req_ready is 1 only in the idle state. A request raised while req_ready is 0 has no effect on the memory pins, and no operation follows it.
- R9: A write accepted when the previous operation was a read first spends the output-enable-to-high-impedance ceiling (20 ns, at least 1 cycle) with all enables high and mem_dq_oe=0. A write that follows a write has no such delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done after a read |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable for the pad |
| mem_dq_i | input | 8 | Byte sampled from the data bus |

## Verification
Several pin rules are checked by the assertions on every cycle: the controller never drives the bus while the memory's outputs are enabled, a read never has the strobe low, select and strobe fall together with data already driven, the bus and address are held at the rising strobe, the strobe pulse meets its minimum width, and done lasts a single cycle. Only the bench's scenarios can show the exact cycle counts of each phase, that the turnaround appears only after a read, that a request raised while busy is dropped, and that bytes written through the pins come back on later reads.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_DOE_NS      = 25,
  parameter int T_HZOE_NS     = 20,
  parameter int T_WC_NS       = 55,
  parameter int T_PWE_NS      = 40,
  parameter int T_AW_NS       = 45,
  parameter int T_SD_NS       = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int ns2cyc(int ns);
    if (ns <= 0) return 0;
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = imax(1, imax(ns2cyc(T_RC_NS), imax(ns2cyc(T_AA_NS), ns2cyc(T_DOE_NS))));
  localparam int WR_CYC   = imax(1, imax(ns2cyc(T_PWE_NS), imax(ns2cyc(T_AW_NS) - 1, ns2cyc(T_SD_NS) - 1)));
  localparam int HOLD_CYC = imax(1, ns2cyc(T_WC_NS) - WR_CYC - 1);
  localparam int TURN_CYC = imax(1, ns2cyc(T_HZOE_NS));
  localparam int PWE_CYC  = ns2cyc(T_PWE_NS);
  localparam int MAX_CYC  = imax(imax(RD_CYC, WR_CYC), imax(HOLD_CYC, TURN_CYC));
  localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_WRITE, S_HOLD, S_READ} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               last_rd;

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      last_rd   <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          if (req_write) begin
            mem_dq_o <= req_wdata;
            last_rd  <= 1'b0;
            if (last_rd) begin
              state <= S_TURN;
              cnt   <= CNT_W'(TURN_CYC - 1);
            end else begin
              state     <= S_SETUP;
              mem_dq_oe <= 1'b1;
            end
          end else begin
            last_rd  <= 1'b1;
            state    <= S_READ;
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            state     <= S_SETUP;
            mem_dq_oe <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_SETUP: begin
          state    <= S_WRITE;
          mem_ce_n <= 1'b0;
          mem_we_n <= 1'b0;
          cnt      <= CNT_W'(WR_CYC - 1);
        end
        S_WRITE: begin
          if (cnt == '0) begin
            state    <= S_HOLD;
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            cnt      <= CNT_W'(HOLD_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt == '0) begin
            state     <= S_IDLE;
            mem_dq_oe <= 1'b0;
            rsp_done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_READ: begin
          if (cnt == '0) begin
            state     <= S_IDLE;
            rsp_rdata <= mem_dq_i;
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            rsp_done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] we_low_run;
  always_ff @(posedge clk) begin
    if (rst) we_low_run <= '0;
    else if (!mem_we_n) we_low_run <= we_low_run + 1'b1;
    else we_low_run <= '0;
  end

  a_r7_bus_only_when_oe_high: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r2_read_keeps_we_high: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

  a_r4_ce_we_fall_together: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($fell(mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr)));

  a_r6_data_held_at_we_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

  a_r5_we_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_run >= (CNT_W+1)'(PWE_CYC)));

  a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int TCLK = 20;

  function automatic int cdiv(int ns);
    return (ns + TCLK - 1) / TCLK;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(1, mx(cdiv(55), mx(cdiv(55), cdiv(25))));
  localparam int E_WR   = mx(1, mx(cdiv(40), mx(cdiv(45) - 1, cdiv(25) - 1)));
  localparam int E_HOLD = mx(1, cdiv(55) - E_WR - 1);
  localparam int E_TURN = mx(1, cdiv(20));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hzz;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit last_rd_b = 1'b0;

  logic [7:0] sram [int];
  logic [7:0] expect_mem [int];
  bit         pend_wr = 1'b0;
  logic [14:0] pend_a;
  logic [7:0]  pend_d;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] dflt(logic [14:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // pin-level memory model
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      pend_wr = 1'b1;
      pend_a  = mem_addr;
      pend_d  = mem_dq_o;
    end else if (pend_wr) begin
      sram[int'(pend_a)] = pend_d;
      pend_wr = 1'b0;
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : dflt(mem_addr);
    else
      mem_dq_i = 8'hzz;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 5000)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cmp(string req, string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  // compare all outputs at the current negedge, then advance one clock
  task automatic cyc(string req, bit ce, bit oe, bit we, bit dqoe, bit rdy, bit dn,
                     logic [14:0] a, logic [7:0] d);
    cmp(req, "ce_n", int'(mem_ce_n), int'(ce));
    cmp(req, "oe_n", int'(mem_oe_n), int'(oe));
    cmp(req, "we_n", int'(mem_we_n), int'(we));
    cmp(req, "dq_oe", int'(mem_dq_oe), int'(dqoe));
    cmp(req, "ready", int'(req_ready), int'(rdy));
    cmp(req, "done", int'(rsp_done), int'(dn));
    if (!ce || dqoe) cmp(req, "addr", int'(mem_addr), int'(a));
    if (dqoe) cmp(req, "dq_o", int'(mem_dq_o), int'(d));
    @(negedge clk);
  endtask

  task automatic idle_cycles(int n, string req);
    for (int i = 0; i < n; i++) cyc(req, 1, 1, 1, 0, 1, 0, '0, '0);
  endtask

  task automatic op(bit wr, logic [14:0] a, logic [7:0] d, bit poke);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      if (last_rd_b)
        for (int i = 0; i < E_TURN; i++) cyc("R9", 1, 1, 1, 0, 0, 0, a, d);
      cyc("R4", 1, 1, 1, 1, 0, 0, a, d);
      for (int i = 0; i < E_WR; i++) begin
        if (poke && i == 0) begin
          req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0055;
        end
        cyc("R5", 0, 1, 0, 1, 0, 0, a, d);
        req_valid = 1'b0;
      end
      for (int i = 0; i < E_HOLD; i++) cyc("R6", 1, 1, 1, 1, 0, 0, a, d);
      expect_mem[int'(a)] = d;
      cyc("R3", 1, 1, 1, 0, 1, 1, a, d);
      last_rd_b = 1'b0;
    end else begin
      for (int i = 0; i < E_RD; i++) cyc("R2", 0, 0, 1, 0, 0, 0, a, d);
      cmp("R3", "rdata", int'(rsp_rdata),
          int'(expect_mem.exists(int'(a)) ? expect_mem[int'(a)] : dflt(a)));
      cyc("R3", 1, 1, 1, 0, 1, 1, a, d);
      last_rd_b = 1'b1;
    end
  endtask

  initial begin
    @(negedge clk);
    cyc("R1", 1, 1, 1, 0, 1, 0, '0, '0);
    cyc("R1", 1, 1, 1, 0, 1, 0, '0, '0);
    rst = 1'b0;
    cyc("R1", 1, 1, 1, 0, 1, 0, '0, '0);

    op(0, 15'h0000, 8'h00, 0);          // unwritten location
    op(1, 15'h1234, 8'hC3, 0);          // write right after read: turnaround
    idle_cycles(1, "R3");
    op(1, 15'h7FFF, 8'h81, 0);          // write after write: no turnaround
    op(0, 15'h1234, 8'h00, 0);
    op(0, 15'h7FFF, 8'h00, 0);          // back-to-back reads
    idle_cycles(3, "R9");
    op(1, 15'h0001, 8'h3C, 0);          // read, idle gap, then write: turnaround
    op(1, 15'h4000, 8'hA7, 1);          // request raised while busy must be dropped
    idle_cycles(4, "R8");
    op(0, 15'h4000, 8'h00, 0);
    op(0, 15'h0001, 8'h00, 0);
    op(1, 15'h1234, 8'hFF, 0);          // overwrite
    op(0, 15'h1234, 8'h00, 0);
    op(0, 15'h2222, 8'h00, 0);
    idle_cycles(2, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule